// File: doc/BRIEF.md
# Multithreaded Outstanding-Miss Tracker

This block keeps the bookkeeping for cache requests that a multithreaded core has sent out and not yet seen answered. Each hardware thread owns two small fully associative tables, one for reads and one for writes. Every entry records a line address, the request kind, a prefetch flag and the time the request was issued. The core asks through a combinational admission port whether a new request may go out. It then records the request on the insert port. Completions from the memory side retire entries on the response port, and demand completions come back to the core as a one-cycle hit pulse.

A completion may name its thread. If it does not, the block searches the tables of that kind in every thread and retires the entry that has waited longest. A watchdog starts with the first insert. It rescans every threshold interval while anything is outstanding and raises a sticky deadlock flag when an entry has waited too long. A touch command moves an entry's issue time to the current time. The block also reports the live demand and prefetch counts. All addresses at the ports are line numbers.

Top module: `line_req_tracker`

## Requirements
- R1: Kinds LD=0 and FETCH=1 are stored in the issuing thread's read table, and kinds ST=2 and ATOMIC=3 in its write table. A completion only matches entries in the table kind that `rsp_wr` selects (1 = write).
- R2: `chk_ok` is low whenever the outstanding count is at or above `MAX_OUT`.
- R3: `chk_ok` is low when any thread holds the checked line in either table. It is also low when the target table (`chk_tid`, `chk_wr`) has no free entry. Otherwise it is high.
- R4: An insert of a line already present in the target table overwrites that entry and leaves the count unchanged. An insert of a new line adds one, and a retirement removes one. The count always equals the number of valid entries.
- R5: A completion with `rsp_tid_vld` low retires the matching entry with the greatest age across threads, with ties going to the lower thread. With `rsp_tid_vld` high, only the named thread is searched.
- R6: Retiring a demand entry raises `hit_vld` for the one cycle after the completion edge, with its thread, kind and line. A prefetch entry retires with no hit.
- R7: A completion that matches no entry pulses `rsp_err` for one cycle. It leaves the tables and the count untouched.
- R8: The first insert arms the watchdog. A scan follows every `THR` cycles. A scan that finds an entry aged at or above `THR` (16-bit wrap-safe difference) sets `deadlock`, which stays set until reset.
- R9: The watchdog disarms when the count is zero. The next insert starts a fresh interval, and entries retired in time never raise `deadlock`.
- R10: A touch for a line and thread sets that entry's issue time to the current time.
- R11: `demand_cnt` and `pf_cnt` give the number of valid entries with the prefetch flag clear and set.
- R12: After reset the count is zero, `chk_ok` is high, and `hit_vld`, `rsp_err` and `deadlock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_line | input | LINE_W | Line to test for admission |
| chk_tid | input | TID_W | Thread of the candidate request |
| chk_wr | input | 1 | Candidate is a store or atomic |
| chk_ok | output | 1 | Candidate may issue |
| ins_vld | input | 1 | Record a request |
| ins_line | input | LINE_W | Line of the recorded request |
| ins_tid | input | TID_W | Issuing thread |
| ins_kind | input | 2 | Request kind: 0 LD, 1 FETCH, 2 ST, 3 ATOMIC |
| ins_pf | input | 1 | Request is a prefetch |
| rsp_vld | input | 1 | A completion arrives |
| rsp_wr | input | 1 | Completion is for the write tables |
| rsp_line | input | LINE_W | Completed line |
| rsp_tid_vld | input | 1 | `rsp_tid` is meaningful |
| rsp_tid | input | TID_W | Thread named by the completion |
| touch_vld | input | 1 | Restart an entry's issue time |
| touch_line | input | LINE_W | Line to restart |
| touch_tid | input | TID_W | Thread owning the entry |
| hit_vld | output | 1 | Demand completion toward the core |
| hit_tid | output | TID_W | Thread of the completed request |
| hit_kind | output | 2 | Kind of the completed request |
| hit_line | output | LINE_W | Line of the completed request |
| rsp_err | output | 1 | Completion matched nothing |
| deadlock | output | 1 | Sticky watchdog flag |
| outst_cnt | output | CNT_W | Valid entries in all tables |
| demand_cnt | output | CNT_W | Valid demand entries |
| pf_cnt | output | CNT_W | Valid prefetch entries |

## Verification
The bench puts the same line into two threads' read tables a few cycles apart. It then checks that an untagged completion takes the older one first, and that a tagged completion ignores age. A design that picks by thread index would return the wrong thread. An overwrite of a resident line with a prefetch must leave the count alone. If it does not, the count drifts and admission closes too early. A completion of the wrong kind must raise the error. The watchdog test touches an entry partway through its first interval. A design that ignores the touch flags the entry at the first scan, while a correct one flags it only at the second.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

   typedef enum logic [1:0] {
      KIND_LOAD   = 2'd0,
      KIND_FETCH  = 2'd1,
      KIND_STORE  = 2'd2,
      KIND_ATOMIC = 2'd3
   } req_kind_e;

   // store and atomic live in the write table
   function automatic logic kind_is_write(input logic [1:0] kind);
      return (kind == KIND_STORE) || (kind == KIND_ATOMIC);
   endfunction

endpackage

// File: rtl/lrt_table.sv
module lrt_table #(
   parameter int ENTRIES = 4,
   parameter int LINE_W  = 26,
   parameter int TS_W    = 16,
   parameter int THR     = 256,
   parameter int VC_W    = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TS_W-1:0]   now_i,
   input  logic              ins_en_i,
   input  logic [LINE_W-1:0] ins_line_i,
   input  logic [1:0]        ins_kind_i,
   input  logic              ins_pf_i,
   output logic              new_alloc_o,
   input  logic [LINE_W-1:0] probe_line_i,
   output logic              probe_hit_o,
   output logic              full_o,
   input  logic [LINE_W-1:0] rsp_line_i,
   output logic              rsp_hit_o,
   output logic [TS_W-1:0]   rsp_age_o,
   output logic [1:0]        rsp_kind_o,
   output logic              rsp_pf_o,
   input  logic              clr_en_i,
   input  logic              touch_en_i,
   input  logic [LINE_W-1:0] touch_line_i,
   output logic [VC_W-1:0]   vld_cnt_o,
   output logic [VC_W-1:0]   pf_cnt_o,
   output logic              stale_o
);

   logic [ENTRIES-1:0] vld_q, pf_q;
   logic [LINE_W-1:0]  line_q [ENTRIES];
   logic [1:0]         kind_q [ENTRIES];
   logic [TS_W-1:0]    ts_q   [ENTRIES];

   logic [ENTRIES-1:0] ins_match, rsp_match, probe_match, touch_match;
   logic [ENTRIES-1:0] stale_vec, free_oh, ins_sel;
   logic               ins_resident;

   always_comb begin
      ins_match   = '0;
      rsp_match   = '0;
      probe_match = '0;
      touch_match = '0;
      stale_vec   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         ins_match[i]   = vld_q[i] && (line_q[i] == ins_line_i);
         rsp_match[i]   = vld_q[i] && (line_q[i] == rsp_line_i);
         probe_match[i] = vld_q[i] && (line_q[i] == probe_line_i);
         touch_match[i] = vld_q[i] && (line_q[i] == touch_line_i);
         stale_vec[i]   = vld_q[i] && (TS_W'(now_i - ts_q[i]) >= TS_W'(THR));
      end
   end

   // lowest free slot, one-hot
   always_comb begin
      free_oh = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_oh    = '0;
            free_oh[i] = 1'b1;
         end
      end
   end

   assign ins_resident = |ins_match;
   assign full_o       = &vld_q;
   assign ins_sel      = ins_resident ? ins_match : free_oh;
   assign new_alloc_o  = ins_en_i && !ins_resident && !full_o;
   assign probe_hit_o  = |probe_match;
   assign rsp_hit_o    = |rsp_match;
   assign stale_o      = |stale_vec;
   assign vld_cnt_o    = VC_W'($countones(vld_q));
   assign pf_cnt_o     = VC_W'($countones(vld_q & pf_q));

   always_comb begin
      rsp_age_o  = '0;
      rsp_kind_o = '0;
      rsp_pf_o   = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (rsp_match[i]) begin
            rsp_age_o  = TS_W'(now_i - ts_q[i]);
            rsp_kind_o = kind_q[i];
            rsp_pf_o   = pf_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         pf_q  <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            line_q[i] <= '0;
            kind_q[i] <= '0;
            ts_q[i]   <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (clr_en_i && rsp_match[i]) begin
               vld_q[i] <= 1'b0;
            end else if (ins_en_i && ins_sel[i]) begin
               vld_q[i]  <= 1'b1;
               pf_q[i]   <= ins_pf_i;
               line_q[i] <= ins_line_i;
               kind_q[i] <= ins_kind_i;
               ts_q[i]   <= now_i;
            end else if (touch_en_i && touch_match[i]) begin
               ts_q[i] <= now_i;
            end
         end
      end
   end

   logic dup_line;
   always_comb begin
      dup_line = 1'b0;
      for (int i = 0; i < ENTRIES; i++)
         for (int j = i + 1; j < ENTRIES; j++)
            if (vld_q[i] && vld_q[j] && (line_q[i] == line_q[j])) dup_line = 1'b1;
   end

   // R4: an overwrite never leaves two copies of one line
   p_single_line_r4: assert property (@(posedge clk) disable iff (!rst_n) !dup_line);

endmodule

// File: rtl/lrt_oldest.sv
module lrt_oldest #(
   parameter int N     = 4,
   parameter int TS_W  = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]           cand_i,
   input  logic [N-1:0][TS_W-1:0] age_i,
   output logic                   any_o,
   output logic [IDX_W-1:0]       idx_o
);

   logic [TS_W-1:0] best;

   // strictly greater age replaces, so ties stay with the lower index
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (cand_i[i] && (!any_o || (age_i[i] > best))) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
            best  = age_i[i];
         end
      end
   end

endmodule

// File: rtl/lrt_watch.sv
module lrt_watch #(
   parameter int THR = 256,
   parameter int TW  = (THR > 2) ? $clog2(THR) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ins_any_i,
   input  logic idle_i,
   input  logic stale_any_i,
   output logic flag_o
);

   logic          armed_q;
   logic [TW-1:0] timer_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         timer_q <= '0;
         flag_o  <= 1'b0;
      end else if (ins_any_i && !armed_q) begin
         armed_q <= 1'b1;
         timer_q <= '0;
      end else if (armed_q && idle_i && !ins_any_i) begin
         armed_q <= 1'b0;
         timer_q <= '0;
      end else if (armed_q) begin
         if (timer_q == TW'(THR - 1)) begin
            timer_q <= '0;
            if (stale_any_i) flag_o <= 1'b1;
         end else begin
            timer_q <= timer_q + 1'b1;
         end
      end
   end

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) flag_o |=> flag_o);
   p_disarm_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && idle_i && !ins_any_i) |=> !armed_q);

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker #(
   parameter int THREADS = 2,
   parameter int ENTRIES = 4,
   parameter int LINE_W  = 26,
   parameter int MAX_OUT = 8,
   parameter int THR     = 256,
   parameter int TS_W    = 16,
   parameter int TID_W   = $clog2(THREADS),
   parameter int CNT_W   = $clog2(THREADS * 2 * ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] chk_line,
   input  logic [TID_W-1:0]  chk_tid,
   input  logic              chk_wr,
   output logic              chk_ok,
   input  logic              ins_vld,
   input  logic [LINE_W-1:0] ins_line,
   input  logic [TID_W-1:0]  ins_tid,
   input  logic [1:0]        ins_kind,
   input  logic              ins_pf,
   input  logic              rsp_vld,
   input  logic              rsp_wr,
   input  logic [LINE_W-1:0] rsp_line,
   input  logic              rsp_tid_vld,
   input  logic [TID_W-1:0]  rsp_tid,
   input  logic              touch_vld,
   input  logic [LINE_W-1:0] touch_line,
   input  logic [TID_W-1:0]  touch_tid,
   output logic              hit_vld,
   output logic [TID_W-1:0]  hit_tid,
   output logic [1:0]        hit_kind,
   output logic [LINE_W-1:0] hit_line,
   output logic              rsp_err,
   output logic              deadlock,
   output logic [CNT_W-1:0]  outst_cnt,
   output logic [CNT_W-1:0]  demand_cnt,
   output logic [CNT_W-1:0]  pf_cnt
);
   import lrt_pkg::*;

   localparam int NT    = THREADS * 2;
   localparam int SEL_W = TID_W + 1;
   localparam int VC_W  = $clog2(ENTRIES + 1);

   if (THREADS < 2) begin : g_bad_threads
      $error("THREADS must be at least 2");
   end
   if (THR < 2 || THR >= (1 << (TS_W - 1))) begin : g_bad_thr
      $error("THR must lie between 2 and half the time counter range");
   end
   if (MAX_OUT < 1 || MAX_OUT > NT * ENTRIES) begin : g_bad_max
      $error("MAX_OUT must lie between 1 and the total entry count");
   end

   logic [TS_W-1:0]  now_q;
   logic [CNT_W-1:0] outst_q, vld_sum, pf_sum, alloc_sum;

   logic [NT-1:0]            ins_en, new_alloc, probe_hit, full, rsp_hit, rsp_pf;
   logic [NT-1:0]            cand, clr_en, touch_en, stale;
   logic [NT-1:0][TS_W-1:0]  rsp_age;
   logic [NT-1:0][1:0]       rsp_kind;
   logic [NT-1:0][VC_W-1:0]  vcnt, pcnt;

   logic             pick_any, retire, miss;
   logic [SEL_W-1:0] sel, chk_ix;

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      for (genvar w = 0; w < 2; w++) begin : g_kind
         localparam int IX = t * 2 + w;

         assign ins_en[IX]   = ins_vld && (ins_tid == TID_W'(t)) && (kind_is_write(ins_kind) == 1'(w));
         assign cand[IX]     = rsp_hit[IX] && (rsp_wr == 1'(w)) &&
                               (!rsp_tid_vld || (rsp_tid == TID_W'(t)));
         assign clr_en[IX]   = retire && (sel == SEL_W'(IX));
         assign touch_en[IX] = touch_vld && (touch_tid == TID_W'(t));

         lrt_table #(
            .ENTRIES(ENTRIES), .LINE_W(LINE_W), .TS_W(TS_W), .THR(THR), .VC_W(VC_W)
         ) u_tab (
            .clk          (clk),
            .rst_n        (rst_n),
            .now_i        (now_q),
            .ins_en_i     (ins_en[IX]),
            .ins_line_i   (ins_line),
            .ins_kind_i   (ins_kind),
            .ins_pf_i     (ins_pf),
            .new_alloc_o  (new_alloc[IX]),
            .probe_line_i (chk_line),
            .probe_hit_o  (probe_hit[IX]),
            .full_o       (full[IX]),
            .rsp_line_i   (rsp_line),
            .rsp_hit_o    (rsp_hit[IX]),
            .rsp_age_o    (rsp_age[IX]),
            .rsp_kind_o   (rsp_kind[IX]),
            .rsp_pf_o     (rsp_pf[IX]),
            .clr_en_i     (clr_en[IX]),
            .touch_en_i   (touch_en[IX]),
            .touch_line_i (touch_line),
            .vld_cnt_o    (vcnt[IX]),
            .pf_cnt_o     (pcnt[IX]),
            .stale_o      (stale[IX])
         );
      end
   end

   lrt_oldest #(.N(NT), .TS_W(TS_W), .IDX_W(SEL_W)) u_pick (
      .cand_i (cand),
      .age_i  (rsp_age),
      .any_o  (pick_any),
      .idx_o  (sel)
   );

   assign retire = rsp_vld && pick_any;
   assign miss   = rsp_vld && !pick_any;

   lrt_watch #(.THR(THR)) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .ins_any_i   (ins_vld),
      .idle_i      (outst_q == '0),
      .stale_any_i (|stale),
      .flag_o      (deadlock)
   );

   always_comb begin
      vld_sum   = '0;
      pf_sum    = '0;
      alloc_sum = '0;
      for (int i = 0; i < NT; i++) begin
         vld_sum   = vld_sum + CNT_W'(vcnt[i]);
         pf_sum    = pf_sum + CNT_W'(pcnt[i]);
         alloc_sum = alloc_sum + CNT_W'(new_alloc[i]);
      end
   end

   assign chk_ix = {chk_tid, chk_wr};
   assign chk_ok = (outst_q < CNT_W'(MAX_OUT)) && !(|probe_hit) && !full[chk_ix];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q    <= '0;
         outst_q  <= '0;
         hit_vld  <= 1'b0;
         hit_tid  <= '0;
         hit_kind <= '0;
         hit_line <= '0;
         rsp_err  <= 1'b0;
      end else begin
         now_q   <= now_q + 1'b1;
         outst_q <= outst_q + alloc_sum - CNT_W'(retire);
         hit_vld <= retire && !rsp_pf[sel];
         rsp_err <= miss;
         if (retire) begin
            hit_tid  <= sel[SEL_W-1:1];
            hit_kind <= rsp_kind[sel];
            hit_line <= rsp_line;
         end
      end
   end

   assign outst_cnt  = outst_q;
   assign pf_cnt     = pf_sum;
   assign demand_cnt = vld_sum - pf_sum;

   // R4: running count tracks the valid bits held in the tables
   p_count_match_r4: assert property (@(posedge clk) disable iff (!rst_n) outst_q == vld_sum);
   // R6: a hit pulse only follows a completion
   p_hit_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n) hit_vld |-> $past(rsp_vld));
   // R7: an unmatched completion never produces a hit
   p_err_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> !hit_vld);
   // R7: an unmatched completion leaves the count alone
   p_err_keeps_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err && !$past(ins_vld)) |-> (outst_q == $past(outst_q)));

endmodule

// File: tb/line_req_tracker_tb_top.sv
`timescale 1ns/1ps
module line_req_tracker_tb_top;

   localparam int LW = 26;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [LW-1:0] chk_line, ins_line, rsp_line, touch_line, hit_line;
   logic          chk_tid, ins_tid, rsp_tid, touch_tid, hit_tid;
   logic          chk_wr, chk_ok, ins_vld, ins_pf, rsp_vld, rsp_wr, rsp_tid_vld, touch_vld;
   logic [1:0]    ins_kind, hit_kind;
   logic          hit_vld, rsp_err, deadlock;
   logic [CW-1:0] outst_cnt, demand_cnt, pf_cnt;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   line_req_tracker #(
      .THREADS(2), .ENTRIES(2), .LINE_W(LW), .MAX_OUT(3), .THR(32), .TS_W(16)
   ) dut_i (.*);

   localparam logic [LW-1:0] LA = 26'h40, LB = 26'h80, LC = 26'hC0, LD = 26'h100;
   localparam logic [LW-1:0] LE = 26'h140, LF = 26'h180, LG = 26'h1C0;

   // admission vectors: {tid, wr, line, expected chk_ok}
   localparam logic [28:0] ADM_VEC [7] = '{
      {1'b0, 1'b0, LB, 1'b0},
      {1'b0, 1'b0, LD, 1'b1},
      {1'b1, 1'b1, LD, 1'b0},
      {1'b1, 1'b0, LD, 1'b1},
      {1'b0, 1'b1, LC, 1'b0},
      {1'b0, 1'b1, LG, 1'b1},
      {1'b1, 1'b1, LG, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_ins(input logic [LW-1:0] l, input logic t, input logic [1:0] k, input logic pf);
      ins_vld = 1'b1; ins_line = l; ins_tid = t; ins_kind = k; ins_pf = pf;
      tick();
      ins_vld = 1'b0;
   endtask

   task automatic do_rsp(input logic [LW-1:0] l, input logic wr, input logic tv, input logic t);
      rsp_vld = 1'b1; rsp_line = l; rsp_wr = wr; rsp_tid_vld = tv; rsp_tid = t;
      tick();
      rsp_vld = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      chk_line = '0; chk_tid = 0; chk_wr = 0;
      ins_vld = 0; ins_line = '0; ins_tid = 0; ins_kind = 0; ins_pf = 0;
      rsp_vld = 0; rsp_line = '0; rsp_wr = 0; rsp_tid_vld = 0; rsp_tid = 0;
      touch_vld = 0; touch_line = '0; touch_tid = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R12 reset state
      chk("R12 count", outst_cnt, 0);
      chk("R12 chk_ok", chk_ok, 1);
      chk("R12 hit_vld", hit_vld, 0);
      chk("R12 rsp_err", rsp_err, 0);
      chk("R12 deadlock", deadlock, 0);

      // R4/R11 first insert and overwrite with a prefetch
      do_ins(LA, 0, 2'd0, 0);
      chk("R4 new line count", outst_cnt, 1);
      chk("R11 demand", demand_cnt, 1);
      do_ins(LA, 0, 2'd0, 1);
      chk("R4 overwrite count", outst_cnt, 1);
      chk("R11 pf count", pf_cnt, 1);
      chk("R11 demand after overwrite", demand_cnt, 0);

      do_ins(LB, 1, 2'd2, 0);
      do_ins(LC, 1, 2'd3, 0);
      chk("R4 three entries", outst_cnt, 3);
      chk("R11 demand two", demand_cnt, 2);
      chk_line = LD; chk_tid = 0; chk_wr = 0; #1;
      chk("R2 limit reached", chk_ok, 0);

      // R1/R7 write completion for a read-table line
      do_rsp(LA, 1, 0, 0);
      chk("R7 error pulse", rsp_err, 1);
      chk("R7 no hit", hit_vld, 0);
      chk("R1 read entry untouched", outst_cnt, 3);

      // R6 prefetch retires silently
      do_rsp(LA, 0, 0, 0);
      chk("R6 prefetch no hit", hit_vld, 0);
      chk("R4 retire count", outst_cnt, 2);
      chk("R7 error cleared", rsp_err, 0);

      // R3 admission vector table
      for (int v = 0; v < 7; v++) begin
         chk_tid = ADM_VEC[v][28]; chk_wr = ADM_VEC[v][27]; chk_line = ADM_VEC[v][26:1];
         #1;
         chk($sformatf("R3 admission vector %0d", v), chk_ok, ADM_VEC[v][0]);
      end

      // R6 demand hits with thread, kind and line
      do_rsp(LC, 1, 1, 1);
      chk("R6 hit", hit_vld, 1);
      chk("R6 hit thread", hit_tid, 1);
      chk("R6 hit kind", hit_kind, 3);
      chk("R6 hit line", hit_line, LC);
      do_rsp(LB, 1, 0, 0);
      chk("R6 store kind", hit_kind, 2);
      chk("R4 empty", outst_cnt, 0);
      tick();
      chk("R6 one-cycle pulse", hit_vld, 0);

      // R9 no flag once everything retired
      repeat (80) tick();
      chk("R9 idle no deadlock", deadlock, 0);

      // R5 oldest-first across threads
      do_ins(LE, 1, 2'd0, 0);
      repeat (5) tick();
      do_ins(LE, 0, 2'd0, 0);
      do_rsp(LE, 0, 0, 0);
      chk("R5 oldest thread first", hit_tid, 1);
      do_rsp(LE, 0, 0, 0);
      chk("R5 remaining thread", hit_tid, 0);
      chk("R5 hit line", hit_line, LE);

      // R5 named thread overrides age
      do_ins(LE, 0, 2'd1, 0);
      repeat (3) tick();
      do_ins(LE, 1, 2'd0, 0);
      do_rsp(LE, 0, 1, 1);
      chk("R5 named thread", hit_tid, 1);
      chk("R5 named kind", hit_kind, 0);
      do_rsp(LE, 0, 1, 1);
      chk("R7 named thread has no entry", rsp_err, 1);
      do_rsp(LE, 0, 0, 0);
      chk("R5 fetch entry left", hit_kind, 1);
      chk("R5 drained", outst_cnt, 0);
      repeat (3) tick();

      // R10/R8 touch postpones the flag by one scan
      do_ins(LF, 0, 2'd2, 0);
      repeat (19) tick();
      touch_vld = 1'b1; touch_line = LF; touch_tid = 0;
      tick();
      touch_vld = 1'b0;
      repeat (29) tick();
      chk("R10 touched entry not flagged", deadlock, 0);
      repeat (20) tick();
      chk("R8 deadlock raised", deadlock, 1);
      do_rsp(LF, 1, 0, 0);
      chk("R6 late store hit", hit_vld, 1);
      repeat (40) tick();
      chk("R8 flag sticky", deadlock, 1);
      chk("R4 final count", outst_cnt, 0);

      summary();
      $finish;
   end

endmodule